// File: doc/BRIEF.md
# Mid-bit sampling serial receiver

This block turns an asynchronous serial line into bytes. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Parity is not used. The line input should already be filtered. A one-cycle oversampling enable sets the time base: one bit lasts `OS_FACTOR` enable pulses. While the receiver is idle, it checks the line on each enable pulse. The first enable pulse that sees the line low starts a frame. That pulse is phase zero. From then on, a phase counter counts enable pulses modulo `OS_FACTOR`, and a sample is taken each time the counter reaches half of that count. This puts every sample near the middle of its bit.

Completed bytes leave on a valid/ready output with no FIFO. `rx_valid` rises on the cycle a frame completes and stays high until a cycle where `rx_ready` is also high. A serial line cannot be held back, so `rx_ready` gives no back-pressure on reception. If a new frame completes before the consumer takes the previous byte, the new byte and its framing status replace the old ones. `rx_frame_err` travels with the byte it describes.

Top module: `serial_mid_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err` and `rx_data` are all 0.
- R2: An idle receiver starts a frame only on an `os_tick` cycle where `rx_line` is 0. A low line with no tick, or a tick with a high line, leaves it idle.
- R3: The receiver takes each bit's sample on the tick `OS_FACTOR/2` ticks after that bit's first tick. The start tick is phase 0, so bit k is sampled on tick `OS_FACTOR/2 + k*OS_FACTOR` after the start. The line value on all other ticks has no effect.
- R4: The eight samples after the start bit form `rx_data`. The first data sample goes to bit 0 and the last to bit 7. The start bit is not stored.
- R5: If the start-bit sample is 1, the frame is dropped as a glitch. `rx_valid` does not rise, and the receiver returns to idle.
- R6: The tenth sample is the stop bit. On that tick `rx_valid` is set and `rx_frame_err` is set to the inverse of the stop sample. A stop bit of 0 still presents the byte.
- R7: Once set, `rx_valid` stays high until a cycle with `rx_valid` and `rx_ready` both high. It is low on the following cycle unless a frame completes on that same cycle.
- R8: A frame that completes while `rx_valid` is still high replaces `rx_data` and `rx_frame_err`, and `rx_valid` stays high.
- R9: The phase counter and bit counter advance only on `os_tick` cycles. Line activity between ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, one pulse per sub-bit period |
| rx_line | input | 1 | Filtered serial line, idle high |
| rx_ready | input | 1 | Consumer accepts the presented byte |
| rx_valid | output | 1 | A received byte is presented |
| rx_data | output | DATA_W | Received byte |
| rx_frame_err | output | 1 | Stop bit of the presented byte was sampled low |

## Verification
The assertions check several rules on every cycle:
- Frames start only on a ticked low line.
- Nothing moves between ticks.
- `rx_valid` is held until the handshake and cleared by it.
- Every rising edge of `rx_valid` comes from a ticked cycle inside a frame.

Only the bench scenarios can show the following:
- The sample lands exactly mid-bit. The bench drives each data bit's true value only on the middle tick and its inverse on every other tick.
- The byte is assembled least significant bit first, across all 256 values.
- Short start glitches are rejected.
- Framing errors are reported.
- An unread byte is overwritten by the next frame.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    SRX_IDLE  = 1'b0,
    SRX_FRAME = 1'b1
  } srx_state_e;
endpackage

// File: rtl/srx_phase_gen.sv
// Oversampling phase counter: restarted at frame start, emits the mid-bit strobe.
module srx_phase_gen #(
  parameter int OS_FACTOR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic run,
  output logic mid_strobe
);
  localparam int PW   = (OS_FACTOR > 2) ? $clog2(OS_FACTOR) : 1;
  localparam int HALF = OS_FACTOR / 2;
  localparam logic [PW-1:0] TOP_PH  = PW'(OS_FACTOR - 1);
  localparam logic [PW-1:0] HALF_PH = PW'(HALF);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;

  always_comb begin
    phase_nxt = (phase_q == TOP_PH) ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick) begin
      if (restart) begin
        phase_q <= '0;
      end else if (run) begin
        phase_q <= phase_nxt;
      end
    end
  end

  assign mid_strobe = tick && run && !restart && (phase_nxt == HALF_PH);
endmodule

// File: rtl/srx_frame_ctrl.sv
// Frame sequencer: start detection, glitch rejection, shift-in, stop check.
module srx_frame_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              mid_strobe,
  output logic              busy,
  output logic              start_now,
  output logic              done,
  output logic              stop_bad,
  output logic [DATA_W-1:0] shift_data
);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W + 1);

  srx_state_e        state_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shreg_q;

  assign busy      = (state_q == SRX_FRAME);
  assign start_now = (state_q == SRX_IDLE) && tick && !line;
  assign done      = busy && mid_strobe && (idx_q == LAST_IDX);
  assign stop_bad  = !line;
  assign shift_data = shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SRX_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        SRX_IDLE: begin
          if (start_now) begin
            state_q <= SRX_FRAME;
            idx_q   <= '0;
          end
        end
        SRX_FRAME: begin
          if (mid_strobe) begin
            if (idx_q == '0) begin
              if (line) begin
                state_q <= SRX_IDLE;       // start sample high: glitch
              end else begin
                idx_q <= IW'(1);
              end
            end else if (idx_q == LAST_IDX) begin
              state_q <= SRX_IDLE;         // stop bit taken
            end else begin
              shreg_q <= {line, shreg_q[DATA_W-1:1]};
              idx_q   <= idx_q + IW'(1);
            end
          end
        end
        default: state_q <= SRX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_out_stage.sv
// Output holding register with valid/ready; a new load overrides a pending byte.
module srx_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_err,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      err   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      err   <= load_err;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_mid_rx.sv
module serial_mid_rx #(
  parameter int OS_FACTOR = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_frame_err
);
  logic              frame_busy;
  logic              frame_start;
  logic              mid_strobe;
  logic              frame_done;
  logic              stop_bad;
  logic [DATA_W-1:0] shift_data;

  srx_phase_gen #(.OS_FACTOR(OS_FACTOR)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .restart    (frame_start),
    .run        (frame_busy),
    .mid_strobe (mid_strobe)
  );

  srx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .line       (rx_line),
    .mid_strobe (mid_strobe),
    .busy       (frame_busy),
    .start_now  (frame_start),
    .done       (frame_done),
    .stop_bad   (stop_bad),
    .shift_data (shift_data)
  );

  srx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_done),
    .load_data (shift_data),
    .load_err  (stop_bad),
    .ready     (rx_ready),
    .valid     (rx_valid),
    .data      (rx_data),
    .err       (rx_frame_err)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              os_tick,
  input logic              rx_line,
  input logic              rx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_frame_err,
  input logic              frame_busy
);
  p_start_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_busy && os_tick && !rx_line) |=> frame_busy);

  p_no_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_busy && os_tick && rx_line) |=> !frame_busy);

  p_busy_only_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !os_tick |=> $stable(frame_busy));

  p_out_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_tick && !(rx_valid && rx_ready)) |=>
      ($stable(rx_valid) && $stable(rx_data) && $stable(rx_frame_err)));

  p_valid_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !os_tick) |=> !rx_valid);

  p_done_from_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> ($past(os_tick) && $past(frame_busy)));
endmodule

bind serial_mid_rx srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .os_tick      (os_tick),
  .rx_line      (rx_line),
  .rx_ready     (rx_ready),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .rx_frame_err (rx_frame_err),
  .frame_busy   (frame_busy)
);

// File: tb/serial_mid_rx_bench.sv
`timescale 1ns/1ps
module serial_mid_rx_bench;
  localparam int OS   = 8;
  localparam int HALF = OS / 2;
  localparam int DW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          os_tick = 1'b0;
  logic          rx_line = 1'b1;
  logic          rx_ready = 1'b0;
  logic          rx_valid;
  logic [DW-1:0] rx_data;
  logic          rx_frame_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  serial_mid_rx #(.OS_FACTOR(OS), .DATA_W(DW)) u_serial_mid_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One tick: line set with the tick, one idle cycle after. Optional noise gap before.
  task automatic do_tick(input logic v, input bit gap);
    if (gap) begin
      for (int g = 0; g < 5; g++) begin
        @(negedge clk); rx_line = ~v; os_tick = 1'b0;
      end
    end
    @(negedge clk); rx_line = v; os_tick = 1'b1;
    @(negedge clk); os_tick = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    for (int k = 0; k < n; k++) do_tick(1'b1, 1'b0);
  endtask

  // noisy: data bits carry their true value only on the mid tick (R3)
  task automatic send_frame(input logic [7:0] b, input logic stopv, input bit noisy, input bit gaps);
    for (int i = 0; i < 10; i++) begin
      logic bitv;
      bitv = (i == 0) ? 1'b0 : (i == 9) ? stopv : b[i-1];
      for (int p = 0; p < OS; p++) begin
        logic v;
        v = bitv;
        if (noisy && i >= 1 && i <= 8 && p != HALF) v = ~bitv;
        if (i == 9 && p > HALF) v = 1'b1;
        do_tick(v, gaps && (i > 0));
      end
    end
    idle_ticks(2);
  endtask

  task automatic ack();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    chk(rx_frame_err == 1'b0, "R1 ferr", rx_frame_err, 0);
    chk(rx_data == 8'h00, "R1 data", rx_data, 0);

    // R2: low line without ticks must not start a frame
    @(negedge clk); rx_line = 1'b0;
    repeat (40) @(negedge clk);
    rx_line = 1'b1;
    idle_ticks(3);
    send_frame(8'hC3, 1'b1, 1'b0, 1'b0);
    chk(rx_valid && rx_data == 8'hC3, "R2 clean start", rx_data, 8'hC3);
    ack();

    // R3 R4 R9: full byte sweep, mid-only data, noise gaps on some frames
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 1'b1, 1'b1, (b % 17) == 0);
      chk(rx_valid == 1'b1, "R3 valid after frame", rx_valid, 1);
      chk(rx_data == 8'(b), ((b % 17) == 0) ? "R9 data with gaps" : "R4 lsb-first data",
          rx_data, b);
      chk(rx_frame_err == 1'b0, "R6 no ferr", rx_frame_err, 0);
      if ((b % 32) == 0) begin
        repeat (12) @(negedge clk);
        chk(rx_valid == 1'b1, "R7 valid holds", rx_valid, 1);
      end
      ack();
      chk(rx_valid == 1'b0, "R7 cleared by ack", rx_valid, 0);
    end

    // R5: start glitch shorter than half a bit
    for (int p = 0; p < HALF; p++) do_tick(1'b0, 1'b0);
    idle_ticks(OS * 11);
    chk(rx_valid == 1'b0, "R5 glitch rejected", rx_valid, 0);
    send_frame(8'h3C, 1'b1, 1'b0, 1'b0);
    chk(rx_valid && rx_data == 8'h3C, "R5 recovery", rx_data, 8'h3C);
    ack();

    // R6: bad stop bit still presents the byte
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    chk(rx_valid == 1'b1, "R6 valid on bad stop", rx_valid, 1);
    chk(rx_frame_err == 1'b1, "R6 ferr set", rx_frame_err, 1);
    chk(rx_data == 8'h5A, "R6 data on bad stop", rx_data, 8'h5A);

    // R8: overwrite without ack, error flag follows the new byte
    send_frame(8'hA7, 1'b1, 1'b0, 1'b0);
    chk(rx_valid == 1'b1, "R8 valid kept", rx_valid, 1);
    chk(rx_data == 8'hA7, "R8 data replaced", rx_data, 8'hA7);
    chk(rx_frame_err == 1'b0, "R8 ferr replaced", rx_frame_err, 0);
    ack();
    chk(rx_valid == 1'b0, "R7 final clear", rx_valid, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule